// File: doc/BRIEF.md
# Serial Engine DMA Channel

This block is the front end of one DMA direction for a serial engine. One copy, built as a transmit channel, pulls bytes from memory and hands them to the engine's outgoing byte stream. A second copy, built as a receive channel, takes bytes from the engine's incoming stream and stores them to memory. Software programs a 64-bit buffer address as two 32-bit halves, an attribute word and a byte count. Writing the byte count is the final programming step, and that write starts the transfer.

The block reports three events through a status register: completion, end of transfer, and a bus error on the memory port. A status bit is cleared by writing 1 to it. Each event has an interrupt enable. The enables change only through a write-one-to-set register and a write-one-to-clear register, and a separate register reads them back. The interrupt line is high while any status bit is both pending and enabled. A length-in readback reports how many bytes actually passed through the stream.

The receive variant adds three features. A flush command ends a transfer early. An optional zero fill then completes the buffer with zeros. A programmable delay of 0 to 7 cycles holds back the completion status.

Top module: `sedma_channel`

## Requirements
- R1: After synchronous reset every register reads 0, the interrupt output is low, and the block raises no memory request, no stream valid and no stream ready.
- R2: The enables sit at bit 0 (done), bit 1 (end-of-transfer) and bit 2 (bus error). A 1 written to the set register (word 5) sets the matching enable bit. A 1 written to the clear register (word 6) clears it. The enables read back at word 4.
- R3: Writing the length register (word 3) while idle starts a transfer. A length of 0 sets done status with no memory access.
- R4: The transmit channel reads memory at pointer+0, pointer+1, and so on in ascending order, where the pointer is {word 1, word 0}. It presents those bytes in the same order on the outgoing stream and then sets done (status bit 0). It also sets end-of-transfer (status bit 1) only when attribute bit 0 (word 2) is 1.
- R5: The receive channel writes incoming stream bytes in order to pointer+i and then sets done only. Its attribute register ignores writes and reads as 0.
- R6: An error response on the memory port aborts the transfer. It sets status bit 2 and leaves done clear. Length-in (word 8) stays at the number of bytes that had completed, and no further request follows.
- R7: Writing 1s to the status register (word 7) clears those bits. Writing all ones clears every bit.
- R8: The interrupt output equals the OR over the three bits of status AND enable.
- R9: While a transfer runs, writes to the pointer, attribute and length registers have no effect.
- R10: A receive flush (word 9, bit 0) with zero fill off ends the transfer. It sets done and end-of-transfer, and length-in reports the bytes received.
- R11: When zero fill (config word 10, bit 5) is on, a receive flush first writes zero bytes up to the programmed length. It then sets done and end-of-transfer, and length-in still counts only the received bytes.
- R12: The receive delay field (config word 10, bits 8:6) holds back the done status by that many clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Combined interrupt |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Request accepted |
| mem_err | input | 1 | Request failed |
| so_valid | output | 1 | Outgoing stream byte valid |
| so_data | output | 8 | Outgoing stream byte |
| so_ready | input | 1 | Outgoing stream accept |
| si_valid | input | 1 | Incoming stream byte valid |
| si_data | input | 8 | Incoming stream byte |
| si_ready | output | 1 | Incoming stream accept |

## Verification
The bench targets several corner cases.
- A length written during a running transfer: a design that failed to block it would restart the transfer or shorten it, and length-in would come out wrong.
- A zero length: a design that got it wrong would touch memory or hang busy.
- A bus error partway through a transfer: a design that got it wrong would keep going or set done.
- A flush with zero fill on and with it off: a design that got it wrong would either stop without filling the buffer or count the fill bytes in length-in.

The receive delay is measured as the exact gap in cycles between the last memory write and the moment status appears, once with no delay and once with a delay. An off-by-one counter shows up as a lag that is one cycle too long or too short.

// File: rtl/sedma_pkg.sv
package sedma_pkg;
    localparam int REG_W = 32;
    localparam int REG_AW = 4;
    localparam int NIRQ = 3;
    localparam int IRQ_DONE = 0;
    localparam int IRQ_EOT = 1;
    localparam int IRQ_ERR = 2;
    localparam int CFG_PAD_BIT = 5;
    localparam int CFG_DLY_LO = 6;
    localparam int DLY_W = 3;

    typedef enum logic [REG_AW-1:0] {
        A_PTR_LO  = 4'd0,
        A_PTR_HI  = 4'd1,
        A_ATTR    = 4'd2,
        A_LEN     = 4'd3,
        A_IEN     = 4'd4,
        A_IEN_SET = 4'd5,
        A_IEN_CLR = 4'd6,
        A_STAT    = 4'd7,
        A_LEN_IN  = 4'd8,
        A_FLUSH   = 4'd9,
        A_GCFG    = 4'd10
    } reg_addr_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_PUSH, ST_POP, ST_STORE, ST_HOLD
    } eng_state_e;

    typedef struct packed {
        logic             start;
        logic             flush;
        logic             eot_attr;
        logic             pad_en;
        logic [DLY_W-1:0] dly;
    } eng_ctrl_t;

    typedef struct packed {
        logic err;
        logic eot;
        logic fin;
    } eng_evt_t;

    function automatic logic pending_any(input logic [NIRQ-1:0] st,
                                         input logic [NIRQ-1:0] en);
        return |(st & en);
    endfunction
endpackage

// File: rtl/sedma_regs.sv
module sedma_regs
    import sedma_pkg::*;
#(
    parameter bit IS_RX  = 1'b0,
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [REG_AW-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    input  logic                busy,
    input  eng_evt_t            evt,
    input  logic [LEN_W-1:0]    len_in,
    output logic [ADDR_W-1:0]   ptr,
    output logic [LEN_W-1:0]    start_len,
    output eng_ctrl_t           ctrl,
    output logic [NIRQ-1:0]     ien,
    output logic [NIRQ-1:0]     status
);
    localparam int HI_W = ADDR_W - REG_W;

    logic [REG_W-1:0] ptr_lo;
    logic [HI_W-1:0]  ptr_hi;
    logic             attr_eot;
    logic [LEN_W-1:0] len;
    logic             pad_en;
    logic [DLY_W-1:0] dly;
    logic [NIRQ-1:0]  status_n;

    assign ptr       = {ptr_hi, ptr_lo};
    assign start_len = wdata[LEN_W-1:0];

    always_comb begin
        ctrl          = '0;
        ctrl.start    = wr && (addr == A_LEN) && !busy;
        ctrl.flush    = IS_RX && wr && (addr == A_FLUSH) && wdata[0];
        ctrl.eot_attr = attr_eot;
        ctrl.pad_en   = pad_en;
        ctrl.dly      = dly;
    end

    always_comb begin
        status_n = status;
        if (wr && addr == A_STAT)
            status_n = status_n & ~wdata[NIRQ-1:0];
        status_n[IRQ_DONE] = status_n[IRQ_DONE] | evt.fin;
        status_n[IRQ_EOT]  = status_n[IRQ_EOT]  | (evt.fin & evt.eot);
        status_n[IRQ_ERR]  = status_n[IRQ_ERR]  | evt.err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_lo   <= '0;
            ptr_hi   <= '0;
            attr_eot <= 1'b0;
            len      <= '0;
            ien      <= '0;
            status   <= '0;
            pad_en   <= 1'b0;
            dly      <= '0;
        end else begin
            status <= status_n;
            if (wr) begin
                case (addr)
                    A_PTR_LO:  if (!busy) ptr_lo <= wdata;
                    A_PTR_HI:  if (!busy) ptr_hi <= wdata[HI_W-1:0];
                    A_ATTR:    if (!busy && !IS_RX) attr_eot <= wdata[0];
                    A_LEN:     if (!busy) len <= wdata[LEN_W-1:0];
                    A_IEN_SET: ien <= ien | wdata[NIRQ-1:0];
                    A_IEN_CLR: ien <= ien & ~wdata[NIRQ-1:0];
                    A_GCFG: begin
                        if (IS_RX) begin
                            pad_en <= wdata[CFG_PAD_BIT];
                            dly    <= wdata[CFG_DLY_LO +: DLY_W];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_PTR_LO: rdata = ptr_lo;
            A_PTR_HI: rdata = REG_W'(ptr_hi);
            A_ATTR:   rdata = REG_W'(attr_eot);
            A_LEN:    rdata = REG_W'(len);
            A_IEN:    rdata = REG_W'(ien);
            A_STAT:   rdata = REG_W'(status);
            A_LEN_IN: rdata = REG_W'(len_in);
            A_GCFG:   rdata = REG_W'({dly, pad_en, 5'b0});
            default:  rdata = '0;
        endcase
    end

    assert_len_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && wr && addr == A_LEN) |=> $stable(len));

    assert_ptr_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && wr && addr == A_PTR_LO) |=> $stable(ptr_lo));

    assert_clear_all_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_STAT && wdata[NIRQ-1:0] == '1 && evt == '0)
        |=> status == '0);

    assert_ien_set_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_IEN_SET)
        |=> ((ien & $past(wdata[NIRQ-1:0])) == $past(wdata[NIRQ-1:0])));
endmodule

// File: rtl/sedma_engine.sv
module sedma_engine
    import sedma_pkg::*;
#(
    parameter bit IS_RX  = 1'b0,
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  eng_ctrl_t         ctrl,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [ADDR_W-1:0] ptr,
    output logic              busy,
    output eng_evt_t          evt,
    output logic [LEN_W-1:0]  len_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              so_valid,
    output logic [7:0]        so_data,
    input  logic              so_ready,
    input  logic              si_valid,
    input  logic [7:0]        si_data,
    output logic              si_ready
);
    eng_state_e       state, st_n;
    logic [LEN_W-1:0] cnt, cnt_n, rcv, rcv_n, len_q, len_n;
    logic [7:0]       byte_q, byte_n;
    logic             flush_pend, flush_pend_n;
    logic             padding, padding_n;
    logic             flushed, flushed_n;
    logic             hold_eot, hold_eot_n;
    logic [DLY_W-1:0] dcnt, dcnt_n;
    eng_evt_t         evt_n;
    logic             fin_go, fin_eot, err_go, flush_now;

    assign busy      = (state != ST_IDLE);
    assign mem_req   = (state == ST_FETCH) || (state == ST_STORE);
    assign mem_we    = (state == ST_STORE);
    assign mem_addr  = ptr + ADDR_W'(cnt);
    assign mem_wdata = byte_q;
    assign so_valid  = (state == ST_PUSH);
    assign so_data   = byte_q;
    assign flush_now = flush_pend || ctrl.flush;
    assign si_ready  = (state == ST_POP) && !flush_now;
    assign len_in    = rcv;

    always_comb begin
        st_n         = state;
        cnt_n        = cnt;
        rcv_n        = rcv;
        len_n        = len_q;
        byte_n       = byte_q;
        padding_n    = padding;
        flushed_n    = flushed;
        flush_pend_n = flush_pend | (IS_RX && ctrl.flush && state != ST_IDLE);
        hold_eot_n   = hold_eot;
        dcnt_n       = dcnt;
        fin_go       = 1'b0;
        fin_eot      = 1'b0;
        err_go       = 1'b0;
        evt_n        = '0;
        case (state)
            ST_IDLE: begin
                if (ctrl.start) begin
                    cnt_n        = '0;
                    rcv_n        = '0;
                    len_n        = start_len;
                    padding_n    = 1'b0;
                    flushed_n    = 1'b0;
                    flush_pend_n = 1'b0;
                    if (start_len == '0) begin
                        fin_go  = 1'b1;
                        fin_eot = !IS_RX && ctrl.eot_attr;
                    end else begin
                        st_n = IS_RX ? ST_POP : ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_err) begin
                    err_go = 1'b1;
                    st_n   = ST_IDLE;
                end else if (mem_ack) begin
                    byte_n = mem_rdata;
                    st_n   = ST_PUSH;
                end
            end
            ST_PUSH: begin
                if (so_ready) begin
                    cnt_n = cnt + 1'b1;
                    rcv_n = rcv + 1'b1;
                    if (cnt + 1'b1 == len_q) begin
                        fin_go  = 1'b1;
                        fin_eot = ctrl.eot_attr;
                    end else begin
                        st_n = ST_FETCH;
                    end
                end
            end
            ST_POP: begin
                if (flush_now) begin
                    flushed_n    = 1'b1;
                    flush_pend_n = 1'b0;
                    if (ctrl.pad_en) begin
                        padding_n = 1'b1;
                        byte_n    = 8'h00;
                        st_n      = ST_STORE;
                    end else begin
                        fin_go  = 1'b1;
                        fin_eot = 1'b1;
                    end
                end else if (si_valid) begin
                    byte_n = si_data;
                    rcv_n  = rcv + 1'b1;
                    st_n   = ST_STORE;
                end
            end
            ST_STORE: begin
                if (mem_err) begin
                    err_go = 1'b1;
                    st_n   = ST_IDLE;
                end else if (mem_ack) begin
                    cnt_n = cnt + 1'b1;
                    if (cnt + 1'b1 == len_q) begin
                        fin_go  = 1'b1;
                        fin_eot = flushed;
                    end else if (padding) begin
                        byte_n = 8'h00;
                    end else begin
                        st_n = ST_POP;
                    end
                end
            end
            ST_HOLD: begin
                if (dcnt == DLY_W'(1)) begin
                    evt_n.fin = 1'b1;
                    evt_n.eot = hold_eot;
                    st_n      = ST_IDLE;
                end else begin
                    dcnt_n = dcnt - 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (fin_go) begin
            if (IS_RX && ctrl.dly != '0) begin
                st_n       = ST_HOLD;
                dcnt_n     = ctrl.dly;
                hold_eot_n = fin_eot;
            end else begin
                st_n      = ST_IDLE;
                evt_n.fin = 1'b1;
                evt_n.eot = fin_eot;
            end
        end
        evt_n.err = err_go;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            rcv        <= '0;
            len_q      <= '0;
            byte_q     <= '0;
            padding    <= 1'b0;
            flushed    <= 1'b0;
            flush_pend <= 1'b0;
            hold_eot   <= 1'b0;
            dcnt       <= '0;
            evt        <= '0;
        end else begin
            state      <= st_n;
            cnt        <= cnt_n;
            rcv        <= rcv_n;
            len_q      <= len_n;
            byte_q     <= byte_n;
            padding    <= padding_n;
            flushed    <= flushed_n;
            flush_pend <= flush_pend_n;
            hold_eot   <= hold_eot_n;
            dcnt       <= dcnt_n;
            evt        <= evt_n;
        end
    end

    assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_stream_held_R4: assert property (@(posedge clk) disable iff (rst)
        (so_valid && !so_ready) |=> (so_valid && $stable(so_data)));

    assert_err_stops_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_err) |=> !mem_req);

    assert_in_bounds_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (cnt < len_q));

    assert_pad_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && padding) |-> mem_wdata == 8'h00);
endmodule

// File: rtl/sedma_channel.sv
module sedma_channel
    import sedma_pkg::*;
#(
    parameter bit IS_RX  = 1'b0,
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [63:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              so_valid,
    output logic [7:0]        so_data,
    input  logic              so_ready,
    input  logic              si_valid,
    input  logic [7:0]        si_data,
    output logic              si_ready
);
    logic              busy;
    eng_evt_t          evt;
    eng_ctrl_t         ctrl;
    logic [LEN_W-1:0]  len_in, start_len;
    logic [ADDR_W-1:0] ptr, eaddr;
    logic [NIRQ-1:0]   ien, status;

    sedma_regs #(.IS_RX(IS_RX), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .evt(evt), .len_in(len_in), .ptr(ptr),
        .start_len(start_len), .ctrl(ctrl), .ien(ien), .status(status)
    );

    sedma_engine #(.IS_RX(IS_RX), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst(rst), .ctrl(ctrl), .start_len(start_len), .ptr(ptr),
        .busy(busy), .evt(evt), .len_in(len_in), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(eaddr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .so_valid(so_valid), .so_data(so_data), .so_ready(so_ready),
        .si_valid(si_valid), .si_data(si_data), .si_ready(si_ready)
    );

    assign mem_addr = 64'(eaddr);
    assign irq      = pending_any(status, ien);

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($changed(status) || $changed(ien)));
endmodule

// File: tb/test_sedma_channel.sv
module test_sedma_channel;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;

    logic        t_wr = 0, t_ack = 0, t_err = 0, t_sor = 0, t_siv = 0;
    logic [3:0]  t_addr = 0;
    logic [31:0] t_wdata = 0, t_rdata;
    logic [7:0]  t_rd = 0, t_sid = 0, t_wd, t_sod;
    logic        t_irq, t_req, t_we, t_sov, t_sir;
    logic [63:0] t_maddr;

    logic        r_wr = 0, r_ack = 0, r_err = 0, r_sor = 0, r_siv = 0;
    logic [3:0]  r_addr = 0;
    logic [31:0] r_wdata = 0, r_rdata;
    logic [7:0]  r_rd = 0, r_sid = 0, r_wd, r_sod;
    logic        r_irq, r_req, r_we, r_sov, r_sir;
    logic [63:0] r_maddr;

    sedma_channel #(.IS_RX(1'b0)) i_sedma_channel (
        .clk(clk), .rst(rst), .reg_wr(t_wr), .reg_addr(t_addr), .reg_wdata(t_wdata),
        .reg_rdata(t_rdata), .irq(t_irq), .mem_req(t_req), .mem_we(t_we),
        .mem_addr(t_maddr), .mem_wdata(t_wd), .mem_rdata(t_rd), .mem_ack(t_ack),
        .mem_err(t_err), .so_valid(t_sov), .so_data(t_sod), .so_ready(t_sor),
        .si_valid(t_siv), .si_data(t_sid), .si_ready(t_sir));

    sedma_channel #(.IS_RX(1'b1)) i_sedma_channel_rx (
        .clk(clk), .rst(rst), .reg_wr(r_wr), .reg_addr(r_addr), .reg_wdata(r_wdata),
        .reg_rdata(r_rdata), .irq(r_irq), .mem_req(r_req), .mem_we(r_we),
        .mem_addr(r_maddr), .mem_wdata(r_wd), .mem_rdata(r_rd), .mem_ack(r_ack),
        .mem_err(r_err), .so_valid(r_sov), .so_data(r_sod), .so_ready(r_sor),
        .si_valid(r_siv), .si_data(r_sid), .si_ready(r_sir));

    logic [7:0]  tmem [256];
    logic [7:0]  rexp [64];
    logic [7:0]  rq [$];
    logic [63:0] t_base = 0, r_base = 0;
    int t_idx = 0, t_got = 0, t_reqs = 0, r_widx = 0, r_last = 0;
    bit t_err_arm = 0;
    logic [7:0] t_err_at = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory and stream responder: decides at negedge, handshake at next posedge
    always @(negedge clk) begin
        logic [7:0] b;
        cyc++;
        t_ack = 0; t_err = 0;
        if (t_req === 1'b1) begin
            t_reqs++;
            if (t_err_arm && t_maddr[7:0] == t_err_at) t_err = 1;
            else if (cyc % 3 != 0) begin
                chk(t_maddr == t_base + 64'(t_idx), "R4 read address", t_maddr, t_base + 64'(t_idx));
                t_ack = 1; t_rd = tmem[t_maddr[7:0]]; t_idx++;
            end
        end
        t_sor = (cyc % 4 != 1);
        if (t_sov === 1'b1 && t_sor) begin
            b = tmem[8'(t_base[7:0] + 8'(t_got))];
            chk(t_sod == b, "R4 stream byte", t_sod, b);
            t_got++;
        end
        r_ack = 0; r_err = 0;
        if (r_req === 1'b1 && r_we === 1'b1 && cyc % 3 != 0) begin
            chk(r_maddr == r_base + 64'(r_widx), "R5 write address", r_maddr, r_base + 64'(r_widx));
            chk(r_wd == rexp[r_widx], "R5 write byte", r_wd, rexp[r_widx]);
            r_ack = 1; r_widx++; r_last = cyc;
        end
        r_siv = 0;
        if (rq.size() > 0 && cyc % 5 != 2) begin
            r_siv = 1; r_sid = rq[0];
            if (r_sir === 1'b1) b = rq.pop_front();
        end
    end

    task automatic wr(input bit rx, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        if (rx) begin r_wr = 1; r_addr = a; r_wdata = d; end
        else begin t_wr = 1; t_addr = a; t_wdata = d; end
        @(negedge clk);
        t_wr = 0; r_wr = 0;
    endtask

    task automatic rd(input bit rx, input logic [3:0] a, output logic [31:0] v);
        if (rx) r_addr = a; else t_addr = a;
        #1;
        v = rx ? r_rdata : t_rdata;
    endtask

    task automatic wait_stat(input bit rx, output logic [31:0] v);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            rd(rx, 4'd7, v);
            if (v[2:0] != 0) return;
        end
        chk(0, "watchdog wait", 0, 1);
    endtask

    logic [31:0] v;
    int lag, n0;

    initial begin
        for (int i = 0; i < 256; i++) tmem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(t_irq == 0 && r_irq == 0, "R1 irq", {t_irq, r_irq}, 0);
        chk(t_req == 0 && r_req == 0 && t_sov == 0 && r_sir == 0, "R1 idle outputs", {t_req, r_req, t_sov, r_sir}, 0);
        for (int a = 0; a < 11; a++) begin
            rd(0, 4'(a), v); chk(v == 0, "R1 tx reg", v, 0);
            rd(1, 4'(a), v); chk(v == 0, "R1 rx reg", v, 0);
        end
        // R2 enables
        wr(0, 5, 32'h5); rd(0, 4, v); chk(v == 5, "R2 set", v, 5);
        wr(0, 6, 32'h1); rd(0, 4, v); chk(v == 4, "R2 clear", v, 4);
        wr(0, 5, 32'h2); rd(0, 4, v); chk(v == 6, "R2 set again", v, 6);
        wr(0, 5, 32'h7);
        // R4 TX with end-of-transfer attribute, 64-bit pointer
        t_base = 64'hA5A50001_00000040; t_idx = 0; t_got = 0;
        wr(0, 0, 32'h40); wr(0, 1, 32'hA5A50001); wr(0, 2, 1); wr(0, 3, 10);
        wait_stat(0, v);
        repeat (2) @(negedge clk);
        rd(0, 7, v); chk(v == 3, "R4 done+eot", v, 3);
        rd(0, 8, v); chk(v == 10, "R4 len_in", v, 10);
        chk(t_got == 10, "R4 stream count", t_got, 10);
        chk(t_irq == 1, "R8 irq pending", t_irq, 1);
        wr(0, 7, 32'hFFFFFFFF); rd(0, 7, v); chk(v == 0, "R7 clear all", v, 0);
        chk(t_irq == 0, "R8 irq after clear", t_irq, 0);
        // TX without attribute; R8 masking
        t_base = 64'hA5A50001_00000080; t_idx = 0; t_got = 0;
        wr(0, 0, 32'h80); wr(0, 2, 0); wr(0, 6, 7); wr(0, 3, 5);
        wait_stat(0, v);
        repeat (2) @(negedge clk);
        rd(0, 7, v); chk(v == 1, "R4 done only", v, 1);
        chk(t_irq == 0, "R8 masked", t_irq, 0);
        wr(0, 5, 32'h2); chk(t_irq == 0, "R8 other bit enabled", t_irq, 0);
        wr(0, 5, 32'h1); chk(t_irq == 1, "R8 done enabled", t_irq, 1);
        wr(0, 7, 32'h2); rd(0, 7, v); chk(v == 1, "R7 selective clear", v, 1);
        wr(0, 7, 32'h1);
        // R9 writes while busy are ignored
        t_base = 64'hA5A50001_00000010; t_idx = 0; t_got = 0;
        wr(0, 0, 32'h10); wr(0, 3, 20); wr(0, 3, 3); wr(0, 0, 32'h99);
        wait_stat(0, v);
        repeat (2) @(negedge clk);
        rd(0, 8, v); chk(v == 20, "R9 length kept", v, 20);
        rd(0, 3, v); chk(v == 20, "R9 length reg", v, 20);
        rd(0, 0, v); chk(v == 32'h10, "R9 pointer reg", v, 32'h10);
        chk(t_got == 20, "R9 bytes streamed", t_got, 20);
        wr(0, 7, 32'h7);
        // R3 zero length
        n0 = t_reqs;
        wr(0, 3, 0);
        wait_stat(0, v);
        chk(v == 1, "R3 zero length done", v, 1);
        chk(t_reqs == n0, "R3 no memory access", t_reqs - n0, 0);
        wr(0, 7, 32'h7);
        // R6 bus error at byte 4
        t_base = 64'hA5A50001_00000020; t_idx = 0; t_got = 0;
        t_err_arm = 1; t_err_at = 8'h24;
        wr(0, 0, 32'h20); wr(0, 3, 12);
        wait_stat(0, v);
        repeat (2) @(negedge clk);
        rd(0, 7, v); chk(v == 4, "R6 error only", v, 4);
        rd(0, 8, v); chk(v == 4, "R6 frozen count", v, 4);
        n0 = t_reqs;
        repeat (6) @(negedge clk);
        chk(t_reqs == n0, "R6 no further request", t_reqs - n0, 0);
        t_err_arm = 0;
        wr(0, 7, 32'h7);
        // R5 RX normal
        r_base = 64'h00000003_00000010; r_widx = 0;
        for (int i = 0; i < 8; i++) begin rexp[i] = 8'(8'hC0 + i); rq.push_back(rexp[i]); end
        wr(1, 0, 32'h10); wr(1, 1, 3); wr(1, 2, 1);
        rd(1, 2, v); chk(v == 0, "R5 attribute ignored", v, 0);
        wr(1, 3, 8);
        wait_stat(1, v);
        repeat (2) @(negedge clk);
        rd(1, 7, v); chk(v == 1, "R5 done only", v, 1);
        rd(1, 8, v); chk(v == 8, "R5 len_in", v, 8);
        chk(r_widx == 8, "R5 writes", r_widx, 8);
        wr(1, 7, 32'h7);
        // R10 flush without fill
        r_base = 64'h00000003_00000040; r_widx = 0;
        for (int i = 0; i < 5; i++) begin rexp[i] = 8'(8'h50 + i); rq.push_back(rexp[i]); end
        wr(1, 0, 32'h40); wr(1, 3, 12);
        for (int k = 0; k < 500 && r_widx < 5; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        wr(1, 9, 1);
        wait_stat(1, v);
        repeat (2) @(negedge clk);
        rd(1, 7, v); chk(v == 3, "R10 done+eot", v, 3);
        rd(1, 8, v); chk(v == 5, "R10 len_in", v, 5);
        chk(r_widx == 5, "R10 writes", r_widx, 5);
        wr(1, 7, 32'h7);
        // R11 flush with zero fill
        r_base = 64'h00000003_00000080; r_widx = 0;
        for (int i = 0; i < 9; i++) rexp[i] = (i < 4) ? 8'(8'h90 + i) : 8'h00;
        for (int i = 0; i < 4; i++) rq.push_back(rexp[i]);
        wr(1, 10, 32'h20); wr(1, 0, 32'h80); wr(1, 3, 9);
        for (int k = 0; k < 500 && r_widx < 4; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        wr(1, 9, 1);
        wait_stat(1, v);
        repeat (2) @(negedge clk);
        rd(1, 7, v); chk(v == 3, "R11 done+eot", v, 3);
        rd(1, 8, v); chk(v == 4, "R11 len_in received only", v, 4);
        chk(r_widx == 9, "R11 zero fill writes", r_widx, 9);
        wr(1, 7, 32'h7);
        // R12 completion delay: 0 then 5 cycles
        for (int d = 0; d <= 5; d += 5) begin
            r_base = 64'h00000003_000000A0; r_widx = 0;
            for (int i = 0; i < 3; i++) begin rexp[i] = 8'(8'h11 * (i + 1)); rq.push_back(rexp[i]); end
            wr(1, 10, 32'(d << 6)); wr(1, 0, 32'hA0); wr(1, 3, 3);
            wait_stat(1, v);
            lag = cyc - r_last;
            chk(lag == 2 + d, "R12 status lag", lag, 2 + d);
            chk(v[2:0] == 1, "R12 done", v, 1);
            wr(1, 7, 32'h7);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule